// File: doc/BRIEF.md
# Single-Channel Bus-Mastering Byte Mover

This block copies bytes between one peripheral and system memory while the processor stays out of the data path. Software loads a start address, a byte count, a direction bit and a trigger-mode bit, then pulses a start input. From then on the peripheral paces the work through a request line. The block borrows the shared bus from the processor with a request/grant handshake before it drives any strobe, and answers the peripheral with an acknowledge in each cycle that a byte moves.

Each byte takes one granted bus cycle. In that cycle the source is read and the destination is written, and the data passes straight across. Two pacing modes exist. In single-byte mode every rising edge of the peripheral's request moves one byte, and the bus goes back to the processor after each byte. In burst mode bytes move every granted cycle while the request stays high, and the bus is held for the whole run. When the last byte has moved, a sticky done flag is set, a one-cycle interrupt pulse is raised and the bus is released.

Top module: `bytemover_dma`

## Requirements
- R1: No memory or device strobe (`mem_rd`, `mem_wr`, `dev_rd`, `dev_wr`) is asserted unless `bus_req` and `bus_grant` are both high in that cycle.
- R2: `dev_ack` is high in exactly the cycles in which a byte moves, and in each such cycle exactly one read strobe and one write strobe are asserted.
- R3: With `cfg_burst`=0, exactly one byte moves for each rising edge of `dev_req`. A level held high after its edge moves nothing more.
- R4: With `cfg_burst`=0, `bus_req` is low in the cycle after each byte moves.
- R5: With `cfg_burst`=1, a byte moves in every granted cycle while `dev_req` is high and `bus_req` stays high between those bytes. When `dev_req` is low in a granted cycle, no byte moves and `bus_req` is low in the next cycle.
- R6: With `cfg_to_dev`=0, a byte is read from the device (`dev_rd`) and written to memory (`mem_wr`, `mem_wdata`=`dev_rdata`). With `cfg_to_dev`=1, a byte is read from memory (`mem_rd`) and written to the device (`dev_wr`, `dev_wdata`=`mem_rdata`).
- R7: `mem_addr` starts at `cfg_addr` and rises by one, modulo 2^AW, after each byte. After N bytes it equals `cfg_addr`+N.
- R8: When the byte that brings the count to zero moves, `done` goes high and stays high until the next accepted start. `irq` is high for that one cycle. `busy` and `bus_req` go low.
- R9: A start pulse with `cfg_count`=0 is ignored. `busy`, `bus_req` and `done` keep their values, and a later `dev_req` moves nothing.
- R10: A start pulse while `busy` is high is ignored, and the running transfer keeps its own address and count.
- R11: After reset, `bus_req`, `dev_ack`, all strobes, `busy`, `done` and `irq` are low, and `mem_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | AW | Memory start address, sampled on an accepted start |
| cfg_count | input | CW | Number of bytes to move, sampled on an accepted start |
| cfg_to_dev | input | 1 | 1 = memory to device, 0 = device to memory |
| cfg_burst | input | 1 | 1 = burst while request is high, 0 = one byte per request edge |
| cfg_start | input | 1 | Start pulse |
| bus_req | output | 1 | Request for the shared bus |
| bus_grant | input | 1 | Bus granted by the processor |
| dev_req | input | 1 | Transfer request from the device |
| dev_ack | output | 1 | Acknowledge to the device, high while a byte moves |
| mem_addr | output | AW | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| dev_rd | output | 1 | Device read strobe |
| dev_wr | output | 1 | Device write strobe |
| dev_wdata | output | DW | Device write data |
| dev_rdata | input | DW | Device read data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
A wrong remaining count shows up when the transfer completes: `done` and `irq` arrive early or late, and the number of acknowledges differs from the programmed count. A broken address register shows up one cycle after a byte moves, as a `mem_addr` that has not stepped by one, or as data in the wrong memory cell. A state machine that keeps the bus or loses a request edge shows up within a cycle or two, as `bus_req` still high after a single-byte move or after the burst request drops, or as a byte that never moves. A swapped direction decode corrupts the first byte of a transfer.

// File: rtl/bytemover_dma.sv
module bytemover_dma #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_addr,
  input  logic [CW-1:0] cfg_count,
  input  logic          cfg_to_dev,
  input  logic          cfg_burst,
  input  logic          cfg_start,
  output logic          bus_req,
  input  logic          bus_grant,
  input  logic          dev_req,
  output logic          dev_ack,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          dev_rd,
  output logic          dev_wr,
  output logic [DW-1:0] dev_wdata,
  input  logic [DW-1:0] dev_rdata,
  output logic          busy,
  output logic          done,
  output logic          irq
);
  localparam logic [1:0] S_IDLE = 2'd0, S_ARMED = 2'd1, S_ASK = 2'd2, S_OWN = 2'd3;

  logic [1:0]    st;
  logic [AW-1:0] addr;
  logic [CW-1:0] left;
  logic          to_dev, burst, req_q, pend;

  wire rise = dev_req & ~req_q;
  wire move = (st == S_OWN) & bus_grant & (~burst | dev_req);

  assign bus_req   = st[1];
  assign busy      = st != S_IDLE;
  assign dev_ack   = move;
  assign mem_addr  = addr;
  assign mem_rd    = move & to_dev;
  assign dev_wr    = move & to_dev;
  assign dev_rd    = move & ~to_dev;
  assign mem_wr    = move & ~to_dev;
  assign mem_wdata = dev_rdata;
  assign dev_wdata = mem_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr   <= '0;
      left   <= '0;
      to_dev <= 1'b0;
      burst  <= 1'b0;
      req_q  <= 1'b0;
      pend   <= 1'b0;
      done   <= 1'b0;
      irq    <= 1'b0;
    end else begin
      req_q <= dev_req;
      irq   <= 1'b0;
      pend  <= rise | (pend & ~(move & ~burst));
      case (st)
        S_IDLE: begin
          pend <= 1'b0;
          if (cfg_start && cfg_count != '0) begin
            addr   <= cfg_addr;
            left   <= cfg_count;
            to_dev <= cfg_to_dev;
            burst  <= cfg_burst;
            done   <= 1'b0;
            st     <= S_ARMED;
          end
        end
        S_ARMED: if (burst ? dev_req : (pend | rise)) st <= S_ASK;
        S_ASK:   if (bus_grant) st <= S_OWN;
        default: begin
          if (move) begin
            addr <= addr + 1'b1;
            left <= left - 1'b1;
            if (left == CW'(1)) begin
              st   <= S_IDLE;
              done <= 1'b1;
              irq  <= 1'b1;
            end else if (!burst) begin
              st <= S_ARMED;
            end
          end else if (burst && !dev_req) begin
            st <= S_ARMED;
          end
        end
      endcase
    end
  end
endmodule

module bytemover_dma_chk #(
  parameter int AW = 8,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cfg_count,
  input logic          cfg_start,
  input logic          bus_req,
  input logic          bus_grant,
  input logic          dev_req,
  input logic          dev_ack,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          dev_rd,
  input logic          dev_wr,
  input logic          busy,
  input logic          done,
  input logic          irq,
  input logic [1:0]    st,
  input logic          burst,
  input logic [CW-1:0] left
);
  // R1
  strobe_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd | mem_wr | dev_rd | dev_wr) |-> (bus_req && bus_grant));
  // R2
  ack_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |-> ($countones({mem_rd, mem_wr, dev_rd, dev_wr}) == 2));
  // R2
  strobe_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd | mem_wr | dev_rd | dev_wr) |-> dev_ack);
  // R6
  to_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (dev_rd && !mem_rd && !dev_wr));
  // R6
  to_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_wr |-> (mem_rd && !dev_rd && !mem_wr));
  // R4
  edge_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_ack && !burst) |=> !bus_req);
  // R5
  burst_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd3 && burst && bus_grant && !dev_req) |=> !bus_req);
  // R5
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_ack && burst && left > CW'(1)) |=> bus_req);
  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |=> (mem_addr == AW'($past(mem_addr) + 1'b1)));
  // R8
  irq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done && !busy && !bus_req));
  // R9
  zero_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cfg_start && cfg_count == '0) |=> (!busy && $stable(done)));
endmodule

bind bytemover_dma bytemover_dma_chk #(.AW(AW), .CW(CW)) chk_i (.*);

// File: tb/bytemover_dma_tb_top.sv
module bytemover_dma_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_addr = '0;
  logic [7:0] cfg_count = '0;
  logic       cfg_to_dev = 1'b0, cfg_burst = 1'b0, cfg_start = 1'b0;
  logic       bus_req, bus_grant = 1'b0;
  logic       dev_req = 1'b0, dev_ack;
  logic [7:0] mem_addr, mem_wdata, mem_rdata, dev_wdata, dev_rdata;
  logic       mem_rd, mem_wr, dev_rd, dev_wr, busy, done, irq;

  int checks = 0, fails = 0;
  int acks = 0, irqs = 0, viol = 0, rel_viol = 0;
  logic prev_edge_ack = 1'b0;
  logic [7:0] mem [256];
  logic [7:0] sink [256];
  logic [7:0] dev_rptr = '0, sink_ptr = '0;

  always #5 clk = ~clk;

  bytemover_dma #(.AW(8), .DW(8), .CW(8)) dut_i (.*);

  function automatic logic [7:0] devf(input logic [7:0] x);
    return 8'(x * 3) ^ 8'h5A;
  endfunction

  initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h3C;

  assign mem_rdata = mem[mem_addr];
  assign dev_rdata = devf(dev_rptr);

  always @(posedge clk) begin
    bus_grant <= rst_n ? bus_req : 1'b0;
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (dev_rd) dev_rptr <= dev_rptr + 1'b1;
    if (dev_wr) begin
      sink[sink_ptr] <= dev_wdata;
      sink_ptr <= sink_ptr + 1'b1;
    end
  end

  always @(negedge clk) begin
    #4;
    if (rst_n) begin
      if (dev_ack) acks++;
      if (irq) irqs++;
      if ((mem_rd | mem_wr | dev_rd | dev_wr) && !(bus_req && bus_grant)) viol++;
      if (prev_edge_ack && bus_req) rel_viol++;
      prev_edge_ack = dev_ack && !cfg_burst;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic xfer(input bit dir, input bit bst, input logic [7:0] base,
                      input int cnt, input int split, input bit poke);
    logic [7:0] r0, w0;
    int a0, i0, v0, rv0;
    @(negedge clk);
    r0 = dev_rptr; w0 = sink_ptr; a0 = acks; i0 = irqs; v0 = viol; rv0 = rel_viol;
    cfg_addr = base; cfg_count = 8'(cnt); cfg_to_dev = dir; cfg_burst = bst; cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
    if (poke) begin
      cfg_addr = 8'hC0; cfg_count = 8'd9; cfg_to_dev = ~dir; cfg_start = 1'b1;
      @(negedge clk);
      cfg_start = 1'b0;
      cfg_to_dev = dir;
    end
    if (!bst) begin
      for (int i = 0; i < cnt; i++) begin
        repeat (2) @(negedge clk);
        dev_req = 1'b1;
        @(negedge clk);
        if (i == 0) begin
          repeat (6) @(negedge clk);
          // R3: held level after one edge moves a single byte
          check(acks - a0 == 1, "R3 level held after edge", acks - a0, 1);
        end
        dev_req = 1'b0;
        while (acks - a0 < i + 1) @(negedge clk);
      end
    end else begin
      dev_req = 1'b1;
      while (acks - a0 < split) @(negedge clk);
      if (split < cnt) begin
        dev_req = 1'b0;
        repeat (3) @(negedge clk);
        // R5: burst stops and bus released when request drops
        check(bus_req == 1'b0, "R5 bus released on request low", bus_req, 0);
        check(acks - a0 == split, "R5 bytes before pause", acks - a0, split);
        dev_req = 1'b1;
        while (acks - a0 < cnt) @(negedge clk);
      end
      dev_req = 1'b0;
    end
    repeat (3) @(negedge clk);
    check(acks - a0 == cnt, "R2 ack count", acks - a0, cnt);
    check(irqs - i0 == 1, "R8 single irq pulse", irqs - i0, 1);
    check(done == 1'b1 && busy == 1'b0 && bus_req == 1'b0, "R8 done idle released",
          {done, busy, bus_req}, 3'b100);
    check(mem_addr == 8'(base + cnt), "R7 final address", mem_addr, 8'(base + cnt));
    check(viol == v0, "R1 strobes only under grant", viol - v0, 0);
    if (!bst) check(rel_viol == rv0, "R4 bus released between bytes", rel_viol - rv0, 0);
    for (int i = 0; i < cnt; i++) begin
      if (!dir)
        check(mem[8'(base + i)] == devf(8'(r0 + i)), "R6 device to memory data",
              mem[8'(base + i)], devf(8'(r0 + i)));
      else
        check(sink[8'(w0 + i)] == (8'(base + i) ^ 8'h3C), "R6 memory to device data",
              sink[8'(w0 + i)], 8'(base + i) ^ 8'h3C);
    end
    if (poke) check(acks - a0 == cnt && mem_addr == 8'(base + cnt), "R10 start while busy ignored",
                    mem_addr, 8'(base + cnt));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11
    check(bus_req == 0 && dev_ack == 0 && busy == 0 && done == 0 && irq == 0, "R11 reset outputs",
          {bus_req, dev_ack, busy, done, irq}, 0);
    check((mem_rd | mem_wr | dev_rd | dev_wr) == 0 && mem_addr == 0, "R11 reset strobes/address",
          mem_addr, 0);
    for (int d = 0; d < 2; d++)
      for (int b = 0; b < 2; b++)
        for (int c = 1; c <= 4; c++)
          xfer(d[0], b[0], d ? 8'(16 * c + 8 * b) : 8'(8'h80 + 16 * c + 8 * b), c,
               (b && c > 1) ? c / 2 : c, 1'b0);
    // R7: address wraps at the top of memory
    xfer(1'b1, 1'b1, 8'hFE, 4, 1, 1'b0);
    // R10: start pulse during an active transfer
    xfer(1'b1, 1'b0, 8'h60, 3, 3, 1'b1);
    // R9: zero count start
    begin
      int a0;
      a0 = acks;
      @(negedge clk);
      cfg_count = 8'd0; cfg_start = 1'b1;
      @(negedge clk);
      cfg_start = 1'b0;
      dev_req = 1'b1;
      repeat (5) @(negedge clk);
      check(busy == 0 && bus_req == 0, "R9 zero count no request", {busy, bus_req}, 0);
      check(done == 1'b1, "R9 done unchanged", done, 1);
      check(acks == a0, "R9 no byte moved", acks - a0, 0);
      dev_req = 1'b0;
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule